// File: doc/BRIEF.md
# Banked Cascaded Interrupt Aggregator

This block gathers level-sensitive interrupt requests from ninety-six peripheral lines, grouped into three banks of thirty-two. It also merges two secondary groups into single bits of those banks. The first group is a thirty-two-bit software request register. The second is a thirty-two-line GPIO sub-controller, whose status and mask arrive here as inputs. Each bank has one status view and two independent enable registers. The first enable set drives interrupt line A and the dispatch vector. The second enable set drives line B only.

The processor reaches the block through a small word-addressed register port. Reads are combinational in the same cycle; writes take effect at the clock edge. Software normally reads the vector register after line A rises. That register names the single source to service: the secondary-group source when its merged bit is enabled and pending, otherwise the lowest-numbered enabled pending line, searching bank 0, then 1, then 2. Both output lines and the vector are registered, so they lag their causes by one clock.

Top module: `bank_irq_agg`

## Requirements
- R1: After reset, every enable register (A and B), the software request register and its enable read 0, both output lines are low and the vector word reads 0.
- R2: Status words (addresses 0..2, one per bank) read the current `src_lvl` levels without delay, and writes to them have no effect.
- R3: A source is pending on line A when its status bit and its A-enable bit (addresses 4..6) are both 1; `irq_a` is the OR of all such bits, registered, so it changes one clock after a source or enable change.
- R4: `irq_b` behaves like `irq_a` but uses the B-enable registers (addresses 8..10); B enables never affect `irq_a` or the vector.
- R5: The software request register (address 12) takes the written word, so a 1 sets and a 0 clears each bit; its enable sits at address 13; bank 0 status bit 5 reads the OR of request AND enable.
- R6: Bank 1 status bit 12 reads the OR of `gpio_stat` AND `gpio_mask`.
- R7: Among ordinary bits, the vector names the lowest bank with any enabled pending bit, and the lowest bit index within it; the index field is bank*32+bit.
- R8: When the merged bit of a bank is enabled and pending, the vector names the lowest pending secondary source of that group ahead of that bank's ordinary bits, but not ahead of a lower bank.
- R9: The vector word (address 14) holds valid in bit 31, the class in bits 9:8 (0 ordinary, 1 software, 2 GPIO) and the index in bits 6:0; it reads 0 when nothing is pending on line A.
- R10: The `src_lvl` inputs at the merged positions (bank 0 bit 5, bank 1 bit 12) are ignored, and with a merged bit's A-enable at 0 its group is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 96 | Level request lines, bank b bit i at position b*32+i |
| gpio_stat | input | 32 | GPIO sub-controller status |
| gpio_mask | input | 32 | GPIO sub-controller mask, 1 = allowed |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not selected or unmapped |
| irq_a | output | 1 | Primary interrupt line |
| irq_b | output | 1 | Secondary interrupt line |

## Verification
A corrupted enable or request register shows up as a wrong readback at once. It also shows up one clock later as a wrong level on `irq_a` or `irq_b`. A fault in the priority search or in the merged-bit handling appears only in the vector word, one clock after the pending set changes. The bench therefore builds pending sets that deliberately place a merged bit above and below ordinary bits, and in lower and higher banks. It also samples each line both just before and just after the edge that should move it.

// File: rtl/bank_irq_pkg.sv
package bank_irq_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_SOFT = 2'd1,
    SRC_GPIO = 2'd2
  } src_class_e;

  typedef struct packed {
    logic       valid;
    src_class_e cls;
    logic [6:0] idx;
  } irq_vec_t;

  // Bus view of the vector: valid at 31, class at 9:8, index at 6:0.
  function automatic logic [31:0] vec_word(irq_vec_t v);
    return {v.valid, 21'd0, v.cls, 1'b0, v.idx};
  endfunction

endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/irq_bank_slice.sv
module irq_bank_slice #(
  parameter int W        = 32,
  parameter bit HAS_CASC = 1'b0,
  parameter int CASC_BIT = 0,
  parameter int BW       = $clog2(W)
) (
  input  logic [W-1:0]  src_lvl,
  input  logic          casc_sum,
  input  logic [W-1:0]  en_a,
  input  logic [W-1:0]  en_b,
  output logic [W-1:0]  status,
  output logic [W-1:0]  pend_a,
  output logic [W-1:0]  pend_b,
  output logic          casc_hit,
  output logic          ord_any,
  output logic [BW-1:0] ord_idx
);
  logic [W-1:0] ord_req;

  always_comb begin
    status = src_lvl;
    if (HAS_CASC) status[CASC_BIT] = casc_sum;
  end

  assign pend_a = status & en_a;
  assign pend_b = status & en_b;

  always_comb begin
    ord_req  = pend_a;
    casc_hit = 1'b0;
    if (HAS_CASC) begin
      casc_hit          = pend_a[CASC_BIT];
      ord_req[CASC_BIT] = 1'b0;
    end
  end

  irq_lsb_pick #(.W(W), .IW(BW)) u_pick (
    .req (ord_req),
    .any (ord_any),
    .idx (ord_idx)
  );
endmodule

// File: rtl/bank_irq_regs.sv
module bank_irq_regs #(
  parameter int NB   = 3,
  parameter int W    = 32,
  parameter int SW_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  en_a [NB],
  output logic [W-1:0]  en_b [NB],
  output logic [SW_W-1:0] sw_req,
  output logic [SW_W-1:0] sw_en
);
  // addr[3:2] picks the group, addr[1:0] the bank or the item.
  localparam logic [1:0] GRP_EN_A = 2'd1;
  localparam logic [1:0] GRP_EN_B = 2'd2;
  localparam logic [1:0] GRP_MISC = 2'd3;

  logic       wr_hit;
  logic [1:0] grp;
  logic [1:0] item;
  logic       ld_sw, ld_swen;

  assign wr_hit  = bus_sel & bus_wr;
  assign grp     = bus_addr[3:2];
  assign item    = bus_addr[1:0];
  assign ld_sw   = wr_hit && grp == GRP_MISC && item == 2'd0;
  assign ld_swen = wr_hit && grp == GRP_MISC && item == 2'd1;

  for (genvar b = 0; b < NB; b++) begin : g_en
    logic ld_a, ld_b;
    assign ld_a = wr_hit && grp == GRP_EN_A && int'(item) == b;
    assign ld_b = wr_hit && grp == GRP_EN_B && int'(item) == b;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_a[b] <= '0;
      else if (ld_a) en_a[b] <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_b[b] <= '0;
      else if (ld_b) en_b[b] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_req <= '0;
    else if (ld_sw) sw_req <= bus_wdata[SW_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_en <= '0;
    else if (ld_swen) sw_en <= bus_wdata[SW_W-1:0];
  end
endmodule

// File: rtl/bank_irq_agg.sv
module bank_irq_agg
  import bank_irq_pkg::*;
#(
  parameter int NB        = 3,
  parameter int W         = 32,
  parameter int SUB_W     = 32,
  parameter int SW_BANK   = 0,
  parameter int SW_BIT    = 5,
  parameter int GPIO_BANK = 1,
  parameter int GPIO_BIT  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*W-1:0] src_lvl,
  input  logic [SUB_W-1:0] gpio_stat,
  input  logic [SUB_W-1:0] gpio_mask,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [3:0]      bus_addr,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            irq_a,
  output logic            irq_b
);
  localparam int NBW = NB * W;
  localparam int BW  = $clog2(W);
  localparam int SBW = $clog2(SUB_W);

  logic rst_sync_n;

  logic [W-1:0]     en_a   [NB];
  logic [W-1:0]     en_b   [NB];
  logic [W-1:0]     status [NB];
  logic [W-1:0]     pend_a [NB];
  logic [W-1:0]     pend_b [NB];
  logic [NB-1:0]    casc_hit;
  logic [NB-1:0]    ord_any;
  logic [BW-1:0]    ord_idx [NB];
  logic [NBW-1:0]   pend_a_flat, pend_b_flat;
  logic [SUB_W-1:0] sw_req, sw_en, sw_pend, gpio_pend;
  logic             sw_any, gpio_any;
  logic [SBW-1:0]   sw_idx, gpio_idx;

  irq_vec_t vec_d, vec_q;
  logic     irq_a_d, irq_b_d;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_irq_regs #(.NB(NB), .W(W), .SW_W(SUB_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_a      (en_a),
    .en_b      (en_b),
    .sw_req    (sw_req),
    .sw_en     (sw_en)
  );

  // Secondary groups: software requests and the GPIO sub-controller.
  assign sw_pend   = sw_req & sw_en;
  assign gpio_pend = gpio_stat & gpio_mask;

  irq_lsb_pick #(.W(SUB_W), .IW(SBW)) u_sw_pick (
    .req (sw_pend),
    .any (sw_any),
    .idx (sw_idx)
  );

  irq_lsb_pick #(.W(SUB_W), .IW(SBW)) u_gpio_pick (
    .req (gpio_pend),
    .any (gpio_any),
    .idx (gpio_idx)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam bit IS_SW   = (b == SW_BANK);
    localparam bit IS_GPIO = (b == GPIO_BANK);
    localparam bit HAS     = IS_SW || IS_GPIO;
    localparam int CBIT    = IS_SW ? SW_BIT : (IS_GPIO ? GPIO_BIT : 0);

    logic casc_sum;
    assign casc_sum = IS_SW ? sw_any : (IS_GPIO ? gpio_any : 1'b0);

    irq_bank_slice #(.W(W), .HAS_CASC(HAS), .CASC_BIT(CBIT), .BW(BW)) u_slice (
      .src_lvl  (src_lvl[b*W +: W]),
      .casc_sum (casc_sum),
      .en_a     (en_a[b]),
      .en_b     (en_b[b]),
      .status   (status[b]),
      .pend_a   (pend_a[b]),
      .pend_b   (pend_b[b]),
      .casc_hit (casc_hit[b]),
      .ord_any  (ord_any[b]),
      .ord_idx  (ord_idx[b])
    );

    assign pend_a_flat[b*W +: W] = pend_a[b];
    assign pend_b_flat[b*W +: W] = pend_b[b];
  end

  // Priority: lowest bank wins; within a bank the merged group goes first.
  always_comb begin
    vec_d = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (casc_hit[b]) begin
        vec_d.valid = 1'b1;
        if (b == SW_BANK) begin
          vec_d.cls = SRC_SOFT;
          vec_d.idx = 7'(sw_idx);
        end else begin
          vec_d.cls = SRC_GPIO;
          vec_d.idx = 7'(gpio_idx);
        end
      end else if (ord_any[b]) begin
        vec_d.valid = 1'b1;
        vec_d.cls   = SRC_MAIN;
        vec_d.idx   = 7'(b * W + int'(ord_idx[b]));
      end
    end
  end

  assign irq_a_d = |pend_a_flat;
  assign irq_b_d = |pend_b_flat;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_a <= 1'b0;
      irq_b <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_a <= irq_a_d;
      irq_b <= irq_b_d;
      vec_q <= vec_d;
    end
  end

  // Register read port.
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr[3:2])
        2'd0: for (int b = 0; b < NB; b++)
                if (int'(bus_addr[1:0]) == b) bus_rdata = status[b];
        2'd1: for (int b = 0; b < NB; b++)
                if (int'(bus_addr[1:0]) == b) bus_rdata = en_a[b];
        2'd2: for (int b = 0; b < NB; b++)
                if (int'(bus_addr[1:0]) == b) bus_rdata = en_b[b];
        2'd3: begin
          case (bus_addr[1:0])
            2'd0:    bus_rdata = W'(sw_req);
            2'd1:    bus_rdata = W'(sw_en);
            2'd2:    bus_rdata = W'(vec_word(vec_q));
            default: bus_rdata = '0;
          endcase
        end
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_checks.sv
module irq_agg_checks
  import bank_irq_pkg::*;
#(
  parameter int NBW      = 96,
  parameter int SW_POS   = 5,
  parameter int GPIO_POS = 44
) (
  input logic           clk,
  input logic           rst_n,
  input logic           irq_a,
  input logic           irq_b,
  input logic [NBW-1:0] pend_a_flat,
  input logic [NBW-1:0] pend_b_flat,
  input irq_vec_t       vec
);
  logic [NBW-1:0] pend_q;
  logic [NBW-1:0] below_mask;

  always_ff @(posedge clk) pend_q <= pend_a_flat;

  assign below_mask = (NBW'(1) << vec.idx) - NBW'(1);

  p_irq_a_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_a == $past(|pend_a_flat)));

  p_irq_b_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_b == $past(|pend_b_flat)));

  p_valid_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vec.valid == $past(|pend_a_flat)));

  p_class_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec.valid |-> (vec.cls != 2'd3));

  p_main_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec.valid && vec.cls == SRC_MAIN) |-> pend_q[vec.idx]);

  p_main_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec.valid && vec.cls == SRC_MAIN) |-> ((pend_q & below_mask) == '0));

  p_soft_merged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec.valid && vec.cls == SRC_SOFT) |-> pend_q[SW_POS]);

  p_gpio_merged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec.valid && vec.cls == SRC_GPIO) |-> pend_q[GPIO_POS]);
endmodule

bind bank_irq_agg irq_agg_checks #(
  .NBW      (NB * W),
  .SW_POS   (SW_BANK * W + SW_BIT),
  .GPIO_POS (GPIO_BANK * W + GPIO_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .irq_a       (irq_a),
  .irq_b       (irq_b),
  .pend_a_flat (pend_a_flat),
  .pend_b_flat (pend_b_flat),
  .vec         (vec_q)
);

// File: tb/bank_irq_agg_tb.sv
module bank_irq_agg_tb;
  logic        clk;
  logic        rst_n;
  logic [95:0] src_lvl;
  logic [31:0] gpio_stat, gpio_mask;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_a, irq_b;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [3:0] A_STAT0 = 4'd0, A_ENA0 = 4'd4, A_ENB0 = 4'd8;
  localparam logic [3:0] A_SW = 4'd12, A_SWEN = 4'd13, A_VEC = 4'd14;

  bank_irq_agg u_dut (
    .clk, .rst_n, .src_lvl, .gpio_stat, .gpio_mask,
    .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_a, .irq_b
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [31:0] vw(bit v, int cls, int idx);
    return {v, 21'd0, 2'(cls), 1'b0, 7'(idx)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(string req, logic [31:0] act, logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic read_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk_eq(req, d, exp);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk);
    src_lvl = '0; gpio_stat = '0; gpio_mask = '0;
    for (int b = 0; b < 3; b++) begin
      bus_write(A_ENA0 + 4'(b), 0);
      bus_write(A_ENB0 + 4'(b), 0);
    end
    bus_write(A_SW, 0);
    bus_write(A_SWEN, 0);
    settle();
  endtask

  task automatic t_reset();
    for (int b = 0; b < 3; b++) begin
      read_chk("R1 enA", A_ENA0 + 4'(b), 0);
      read_chk("R1 enB", A_ENB0 + 4'(b), 0);
    end
    read_chk("R1 sw", A_SW, 0);
    read_chk("R1 swen", A_SWEN, 0);
    chk_eq("R1 irq_a", 32'(irq_a), 0);
    chk_eq("R1 irq_b", 32'(irq_b), 0);
    read_chk("R1 R9 vector empty", A_VEC, 0);
  endtask

  task automatic t_status();
    src_lvl = '0;
    src_lvl[3] = 1; src_lvl[5] = 1; src_lvl[95] = 1; src_lvl[44] = 1;
    #1;
    read_chk("R2 R10 status0", A_STAT0, 32'h0000_0008);
    read_chk("R2 R10 status1", A_STAT0 + 4'd1, 32'h0);
    read_chk("R2 status2", A_STAT0 + 4'd2, 32'h8000_0000);
    bus_write(A_STAT0, 32'hFFFF_FFFF);
    read_chk("R2 status write ignored", A_STAT0, 32'h0000_0008);
    clear_all();
  endtask

  task automatic t_irq_a();
    @(negedge clk); src_lvl[39] = 1;
    settle();
    chk_eq("R3 disabled no irq", 32'(irq_a), 0);
    bus_write(A_ENA0 + 4'd1, 32'h80);
    chk_eq("R3 not yet", 32'(irq_a), 0);
    settle();
    chk_eq("R3 irq_a set", 32'(irq_a), 1);
    read_chk("R3 R9 vector", A_VEC, vw(1, 0, 39));
    src_lvl[39] = 0;
    #1 chk_eq("R3 registered hold", 32'(irq_a), 1);
    settle();
    chk_eq("R3 irq_a drop", 32'(irq_a), 0);
    clear_all();
  endtask

  task automatic t_irq_b();
    bus_write(A_ENB0 + 4'd2, 32'h1);
    @(negedge clk); src_lvl[64] = 1;
    settle();
    chk_eq("R4 irq_b", 32'(irq_b), 1);
    chk_eq("R4 irq_a unaffected", 32'(irq_a), 0);
    read_chk("R4 vector unaffected", A_VEC, 0);
    read_chk("R4 enB readback", A_ENB0 + 4'd2, 32'h1);
    clear_all();
  endtask

  task automatic t_sw();
    bus_write(A_SW, 32'h120);
    read_chk("R5 sw readback", A_SW, 32'h120);
    read_chk("R5 no enable", A_STAT0, 0);
    bus_write(A_SWEN, 32'h100);
    read_chk("R5 summary bit", A_STAT0, 32'h20);
    bus_write(A_ENA0, 32'h20);
    settle();
    chk_eq("R5 irq via sw", 32'(irq_a), 1);
    read_chk("R5 R9 vector sw", A_VEC, vw(1, 1, 8));
    bus_write(A_SW, 32'h20);
    read_chk("R5 write clears", A_SW, 32'h20);
    settle();
    chk_eq("R5 irq off", 32'(irq_a), 0);
    clear_all();
  endtask

  task automatic t_gpio();
    @(negedge clk); gpio_stat = 32'h30; gpio_mask = 32'h20;
    #1 read_chk("R6 summary bit", A_STAT0 + 4'd1, 32'h1000);
    bus_write(A_ENA0 + 4'd1, 32'h1000);
    settle();
    chk_eq("R6 irq via gpio", 32'(irq_a), 1);
    read_chk("R6 R9 vector gpio", A_VEC, vw(1, 2, 5));
    @(negedge clk); gpio_mask = 0;
    #1 read_chk("R6 masked", A_STAT0 + 4'd1, 0);
    settle();
    chk_eq("R6 irq off", 32'(irq_a), 0);
    clear_all();
  endtask

  task automatic t_priority();
    for (int b = 0; b < 3; b++) bus_write(A_ENA0 + 4'(b), 32'hFFFF_FFFF);
    @(negedge clk); src_lvl[35] = 1; src_lvl[65] = 1; src_lvl[20] = 1;
    settle();
    read_chk("R7 bank0 first", A_VEC, vw(1, 0, 20));
    src_lvl[20] = 0; src_lvl[60] = 1;
    settle();
    read_chk("R7 bank1 lowest bit", A_VEC, vw(1, 0, 35));
    src_lvl[35] = 0; src_lvl[60] = 0; src_lvl[90] = 1;
    settle();
    read_chk("R7 bank2 lowest bit", A_VEC, vw(1, 0, 65));
    clear_all();
  endtask

  task automatic t_cascade();
    for (int b = 0; b < 3; b++) bus_write(A_ENA0 + 4'(b), 32'hFFFF_FFFF);
    bus_write(A_SW, 32'h200);
    bus_write(A_SWEN, 32'hFFFF_FFFF);
    @(negedge clk); src_lvl[0] = 1;
    settle();
    read_chk("R8 sw over bank0 bit0", A_VEC, vw(1, 1, 9));
    bus_write(A_SW, 0);
    @(negedge clk); src_lvl[0] = 0; src_lvl[32] = 1; gpio_stat = 32'h4; gpio_mask = 32'hF;
    settle();
    read_chk("R8 gpio over bank1 bit0", A_VEC, vw(1, 2, 2));
    src_lvl[31] = 1;
    settle();
    read_chk("R8 lower bank beats gpio", A_VEC, vw(1, 0, 31));
    clear_all();
  endtask

  task automatic t_ignore();
    bus_write(A_ENA0, 32'hFFFF_FFDF);
    bus_write(A_SW, 32'h1);
    bus_write(A_SWEN, 32'h1);
    @(negedge clk); src_lvl[5] = 1; src_lvl[44] = 1;
    settle();
    read_chk("R10 merged bit shows", A_STAT0, 32'h20);
    chk_eq("R10 irq off", 32'(irq_a), 0);
    read_chk("R10 R9 vector empty", A_VEC, 0);
    read_chk("R10 src at gpio slot ignored", A_STAT0 + 4'd1, 0);
    clear_all();
  endtask

  initial begin
    rst_n = 0; src_lvl = '0; gpio_stat = '0; gpio_mask = '0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_status();
    t_irq_a();
    t_irq_b();
    t_sw();
    t_gpio();
    t_priority();
    t_cascade();
    t_ignore();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule